// File: doc/BRIEF.md
# Two-by-Two Write-Channel Router

This block steers the write traffic of two AXI4 masters onto two slaves. It handles the write address (AW), write data (W) and write response (B) channels. The slave is chosen by one address bit. When both masters want the same slave, a round-robin arbiter inside that slave's address slot decides who goes first. Every accepted address records its slave in a small queue owned by the master. Write data is then steered by the head of that queue. A beat that arrives before its address waits until the address has been taken.

Each slave also keeps a queue of the masters it accepted, in acceptance order. Data bursts therefore reach a slave one whole burst at a time, in the same order as the addresses. Toward the slaves the ID grows by one leading bit that names the issuing master. On the way back the router reads that bit to choose the master, then drops it. The read path and the memories are not part of this block.

The address slot of each slave is a two-state machine. AW_IDLE waits for a qualified request. The transition "grant" latches the chosen master and moves to AW_OFFER. AW_OFFER drives the slave's AW valid. The transition "accept" fires when the slave is ready, records both queue entries, moves the arbitration pointer past the winner and returns to AW_IDLE. The response return of each master is also a two-state machine. B_PICK chooses among the slaves that hold a response for this master. The transition "stall" moves to B_HOLD when the master is not ready, freezing the choice. The transition "release" returns to B_PICK on the handshake.

Top module: `axwr_router`

## Requirements
- R1: Address bit SEL_BIT (default 16) of an AW selects the slave: 0 for slave 0, 1 for slave 1. The AW address and length reach that slave unchanged.
- R2: The ID presented to a slave is {master index, master ID}, with master 0 as prefix 0 and master 1 as prefix 1.
- R3: When both masters request the same slave, the slave accepts them alternately. After an AW from one master is accepted, the other master wins the next contention. Starting from reset, master 0 wins first.
- R4: A master's W beat is accepted only after an AW of that master has been accepted whose burst is not yet finished. Until then the master's W ready stays low, even if W valid is high.
- R5: W beats of a master go to the slave recorded for its oldest unfinished AW. The entry is removed after the beat with W last set. Several writes per master may be outstanding at once.
- R6: Each slave receives whole bursts with no interleaving, in the order in which it accepted their AWs.
- R7: A B response goes to the master named by the top bit of its ID, with that bit removed and the response code unchanged.
- R8: A master's AW ready stays low while its route queue holds DEPTH (default 4) writes whose data is unfinished.
- R9: Once AW valid is raised toward a slave, or B valid toward a master, it stays high with the same content until the handshake. This holds under back-pressure.
- R10: During reset no valid is driven toward the slaves, no B valid toward the masters, and no AW ready toward the masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awvalid | input | 2 | AW valid, one bit per master |
| m_awready | output | 2 | AW ready, one bit per master |
| m_awid | input | 2*ID_W | AW ID per master |
| m_awaddr | input | 2*ADDR_W | AW address per master |
| m_awlen | input | 2*LEN_W | AW burst length minus one per master |
| m_wdata | input | 2*DATA_W | W data per master |
| m_wstrb | input | 2*DATA_W/8 | W byte strobes per master |
| m_wlast | input | 2 | W last beat per master |
| m_wvalid | input | 2 | W valid per master |
| m_wready | output | 2 | W ready per master |
| m_bid | output | 2*ID_W | B ID per master, prefix removed |
| m_bresp | output | 4 | B response code per master |
| m_bvalid | output | 2 | B valid per master |
| m_bready | input | 2 | B ready per master |
| s_awvalid | output | 2 | AW valid per slave |
| s_awready | input | 2 | AW ready per slave |
| s_awid | output | 2*(ID_W+1) | Widened AW ID per slave |
| s_awaddr | output | 2*ADDR_W | AW address per slave |
| s_awlen | output | 2*LEN_W | AW length per slave |
| s_wdata | output | 2*DATA_W | W data per slave |
| s_wstrb | output | 2*DATA_W/8 | W strobes per slave |
| s_wlast | output | 2 | W last per slave |
| s_wvalid | output | 2 | W valid per slave |
| s_wready | input | 2 | W ready per slave |
| s_bid | input | 2*(ID_W+1) | Widened B ID per slave |
| s_bresp | input | 4 | B response code per slave |
| s_bvalid | input | 2 | B valid per slave |
| s_bready | output | 2 | B ready per slave |

## Verification
The embedded properties rely on both sides following the usual valid/ready rules. A master keeps AW valid and its fields steady until the handshake. A slave keeps B valid and its ID steady until the handshake. A slave returns a B prefix only for a master that sent it a write. The bench masters and slaves keep every valid raised until the matching ready. They produce responses only from their own record of completed bursts. They also limit each master to eight writes awaiting a response, so that every ID in flight stays distinct. Random ready and valid timing is mixed with a directed contention run and a run where one master fills its route queue while the other sends data with no address.

// File: rtl/axwr_pkg.sv
package axwr_pkg;
    localparam int NM = 2;
    localparam int NS = 2;

    typedef enum logic {
        AW_IDLE,
        AW_OFFER
    } aw_state_e;

    typedef enum logic {
        B_PICK,
        B_HOLD
    } b_state_e;
endpackage

// File: rtl/axwr_fifo.sv
module axwr_fifo #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (!push && pop) cnt <= cnt - 1'b1;
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R5
endmodule

// File: rtl/axwr_aw_slot.sv
module axwr_aw_slot import axwr_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          s_awready,
    output logic          s_awvalid,
    output logic          gnt,
    output logic          fire
);
    aw_state_e state, state_nxt;
    logic      ptr;
    logic      pick;

    assign pick = req[ptr] ? ptr : ~ptr;

    always_comb begin
        state_nxt = state;
        unique case (state)
            AW_IDLE:  if (|req)     state_nxt = AW_OFFER;
            AW_OFFER: if (s_awready) state_nxt = AW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= AW_IDLE;
            ptr   <= 1'b0;
            gnt   <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == AW_IDLE && |req) gnt <= pick;
            if (fire) ptr <= ~gnt;
        end
    end

    always_comb begin
        s_awvalid = (state == AW_OFFER);
        fire      = s_awvalid && s_awready;
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && !s_awready) |=> (s_awvalid && $stable(gnt))); // R9
    AST_GRANT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid |-> req[gnt]); // R3
endmodule

// File: rtl/axwr_b_ret.sv
module axwr_b_ret import axwr_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] hit,
    input  logic          m_bready,
    output logic          m_bvalid,
    output logic          sel
);
    b_state_e state, state_nxt;
    logic     ptr;
    logic     held;
    logic     choice;

    assign choice = hit[ptr] ? ptr : (hit[~ptr] ? ~ptr : ptr);

    always_comb begin
        state_nxt = state;
        unique case (state)
            B_PICK: if (m_bvalid && !m_bready) state_nxt = B_HOLD;
            B_HOLD: if (m_bready)              state_nxt = B_PICK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= B_PICK;
            ptr   <= 1'b0;
            held  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == B_PICK && m_bvalid && !m_bready) held <= sel;
            if (m_bvalid && m_bready) ptr <= ~sel;
        end
    end

    always_comb begin
        sel      = (state == B_HOLD) ? held : choice;
        m_bvalid = hit[sel];
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && !m_bready) |=> (m_bvalid && $stable(sel))); // R9
endmodule

// File: rtl/axwr_router.sv
module axwr_router import axwr_pkg::*; #(
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 8,
    parameter int DEPTH   = 4,
    parameter int SEL_BIT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          m_awvalid,
    output logic [NM-1:0]          m_awready,
    input  logic [NM*ID_W-1:0]     m_awid,
    input  logic [NM*ADDR_W-1:0]   m_awaddr,
    input  logic [NM*LEN_W-1:0]    m_awlen,
    input  logic [NM*DATA_W-1:0]   m_wdata,
    input  logic [NM*DATA_W/8-1:0] m_wstrb,
    input  logic [NM-1:0]          m_wlast,
    input  logic [NM-1:0]          m_wvalid,
    output logic [NM-1:0]          m_wready,
    output logic [NM*ID_W-1:0]     m_bid,
    output logic [NM*2-1:0]        m_bresp,
    output logic [NM-1:0]          m_bvalid,
    input  logic [NM-1:0]          m_bready,
    output logic [NS-1:0]          s_awvalid,
    input  logic [NS-1:0]          s_awready,
    output logic [NS*(ID_W+1)-1:0] s_awid,
    output logic [NS*ADDR_W-1:0]   s_awaddr,
    output logic [NS*LEN_W-1:0]    s_awlen,
    output logic [NS*DATA_W-1:0]   s_wdata,
    output logic [NS*DATA_W/8-1:0] s_wstrb,
    output logic [NS-1:0]          s_wlast,
    output logic [NS-1:0]          s_wvalid,
    input  logic [NS-1:0]          s_wready,
    input  logic [NS*(ID_W+1)-1:0] s_bid,
    input  logic [NS*2-1:0]        s_bresp,
    input  logic [NS-1:0]          s_bvalid,
    output logic [NS-1:0]          s_bready
);
    localparam int XID_W    = ID_W + 1;
    localparam int STRB_W   = DATA_W / 8;
    localparam int SQ_DEPTH = NM * DEPTH;

    logic          tgt      [NM];
    logic          mq_head  [NM];
    logic          mq_full  [NM];
    logic          mq_empty [NM];
    logic          mq_push  [NM];
    logic          mq_pop   [NM];
    logic          sq_head  [NS];
    logic          sq_full  [NS];
    logic          sq_empty [NS];
    logic          sq_pop   [NS];
    logic [NM-1:0] req      [NS];
    logic          gnt      [NS];
    logic          fire     [NS];
    logic          bpre     [NS];
    logic [NS-1:0] bhit     [NM];
    logic          bsel     [NM];

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_awready[m] = 1'b0;
            for (int s = 0; s < NS; s++)
                if (fire[s] && int'(gnt[s]) == m) m_awready[m] = 1'b1;
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
        assign tgt[m]     = m_awaddr[m*ADDR_W + SEL_BIT];
        assign mq_push[m] = m_awvalid[m] && m_awready[m];
        assign mq_pop[m]  = m_wvalid[m] && m_wready[m] && m_wlast[m];

        axwr_fifo #(.WIDTH(1), .DEPTH(DEPTH)) u_route (
            .clk(clk), .rst_n(rst_n), .push(mq_push[m]), .din(tgt[m]),
            .pop(mq_pop[m]), .head(mq_head[m]), .full(mq_full[m]),
            .empty(mq_empty[m]));

        assign m_wready[m] = !mq_empty[m] && !sq_empty[mq_head[m]]
                          && int'(sq_head[mq_head[m]]) == m
                          && s_wready[mq_head[m]];

        for (genvar s = 0; s < NS; s++) begin : g_hit
            assign bhit[m][s] = s_bvalid[s] && int'(bpre[s]) == m;
        end

        axwr_b_ret u_bret (
            .clk(clk), .rst_n(rst_n), .hit(bhit[m]), .m_bready(m_bready[m]),
            .m_bvalid(m_bvalid[m]), .sel(bsel[m]));

        assign m_bid[m*ID_W +: ID_W] = s_bid[int'(bsel[m])*XID_W +: ID_W];
        assign m_bresp[m*2 +: 2]     = s_bresp[int'(bsel[m])*2 +: 2];

        AST_AWREADY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            mq_full[m] |-> !m_awready[m]); // R8
        AST_W_AFTER_AW: assert property (@(posedge clk) disable iff (!rst_n)
            mq_empty[m] |-> !m_wready[m]); // R4
        AST_B_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            m_bvalid[m] |-> int'(s_bid[int'(bsel[m])*XID_W + ID_W]) == m); // R7
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        for (genvar m = 0; m < NM; m++) begin : g_req
            assign req[s][m] = m_awvalid[m] && int'(tgt[m]) == s
                            && !mq_full[m] && !sq_full[s];
        end

        axwr_aw_slot u_slot (
            .clk(clk), .rst_n(rst_n), .req(req[s]), .s_awready(s_awready[s]),
            .s_awvalid(s_awvalid[s]), .gnt(gnt[s]), .fire(fire[s]));

        assign s_awid[s*XID_W +: XID_W]    = {gnt[s], m_awid[int'(gnt[s])*ID_W +: ID_W]};
        assign s_awaddr[s*ADDR_W +: ADDR_W] = m_awaddr[int'(gnt[s])*ADDR_W +: ADDR_W];
        assign s_awlen[s*LEN_W +: LEN_W]    = m_awlen[int'(gnt[s])*LEN_W +: LEN_W];

        assign sq_pop[s] = s_wvalid[s] && s_wready[s] && s_wlast[s];

        axwr_fifo #(.WIDTH(1), .DEPTH(SQ_DEPTH)) u_order (
            .clk(clk), .rst_n(rst_n), .push(fire[s]), .din(gnt[s]),
            .pop(sq_pop[s]), .head(sq_head[s]), .full(sq_full[s]),
            .empty(sq_empty[s]));

        assign s_wvalid[s] = !sq_empty[s] && !mq_empty[sq_head[s]]
                          && int'(mq_head[sq_head[s]]) == s
                          && m_wvalid[sq_head[s]];
        assign s_wdata[s*DATA_W +: DATA_W] = m_wdata[int'(sq_head[s])*DATA_W +: DATA_W];
        assign s_wstrb[s*STRB_W +: STRB_W] = m_wstrb[int'(sq_head[s])*STRB_W +: STRB_W];
        assign s_wlast[s]                  = m_wlast[sq_head[s]];

        assign bpre[s]     = s_bid[s*XID_W + ID_W];
        assign s_bready[s] = m_bready[bpre[s]] && int'(bsel[bpre[s]]) == s;

        AST_W_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            s_wvalid[s] |-> (m_wvalid[sq_head[s]] && !mq_empty[sq_head[s]])); // R6
    end
endmodule

// File: tb/axwr_router_bench.sv
`timescale 1ns/1ps
module axwr_router_bench;
    localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, LEN_W = 8;
    localparam int DEPTH = 4, SEL_BIT = 16, XID_W = ID_W + 1;
    localparam int NT = 40, QS = 128, WDOG = 20000;

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    logic [1:0]          m_awvalid, m_awready, m_wlast, m_wvalid, m_wready;
    logic [2*ID_W-1:0]   m_awid, m_bid;
    logic [2*ADDR_W-1:0] m_awaddr, s_awaddr;
    logic [2*LEN_W-1:0]  m_awlen, s_awlen;
    logic [2*DATA_W-1:0] m_wdata, s_wdata;
    logic [7:0]          m_wstrb, s_wstrb;
    logic [3:0]          m_bresp, s_bresp;
    logic [1:0]          m_bvalid, m_bready;
    logic [1:0]          s_awvalid, s_awready, s_wlast, s_wvalid, s_wready;
    logic [2*XID_W-1:0]  s_awid, s_bid;
    logic [1:0]          s_bvalid, s_bready;

    axwr_router u_axwr_router (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
        .m_wready(m_wready), .m_bid(m_bid), .m_bresp(m_bresp),
        .m_bvalid(m_bvalid), .m_bready(m_bready),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid),
        .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_wdata(s_wdata),
        .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid),
        .s_wready(s_wready), .s_bid(s_bid), .s_bresp(s_bresp),
        .s_bvalid(s_bvalid), .s_bready(s_bready));

    int total = 0, bad = 0, cycles = 0;
    bit timed_out = 0;
    int phase = 0;

    int          t_tgt  [2][NT];
    int          t_len  [2][NT];
    logic [31:0] t_addr [2][NT];

    int aw_idx[2], w_idx[2], w_beat[2], b_cnt[2], aw_lim[2], w_lim[2];
    bit awv[2], wv[2];
    bit b_got[2][NT];
    int so_m[2][QS], so_k[2][QS], so_wr[2], so_rd[2], sb_beat[2];
    int bq_m[2][QS], bq_k[2][QS], bq_wr[2], bq_rd[2];
    bit bv[2];
    int pr_av, pr_wv, pr_ar, pr_wr, pr_bv, pr_br;
    int g0_log[16], g0_n = 0, slv_aw_total = 0, m1_wready_cnt = 0;
    bit          st_aw[2], st_b[2];
    logic [XID_W-1:0]  st_awid[2];
    logic [31:0] st_addr[2];
    logic [ID_W-1:0]   st_bid[2];

    function automatic logic [31:0] exp_data(int m, int k, int b);
        return 32'(m * 32'h1000_0000 + k * 32'h0001_0000 + b * 3 + 32'h5A);
    endfunction

    function automatic logic [1:0] exp_resp(int m, int k);
        return 2'(k + m);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit roll(int pct);
        return $urandom_range(99) < pct;
    endfunction

    task automatic drive();
        for (int m = 0; m < 2; m++) begin
            int ai, wi;
            if (!awv[m] && aw_idx[m] < aw_lim[m] && (aw_idx[m] - b_cnt[m]) < 8 && roll(pr_av))
                awv[m] = 1;
            ai = (aw_idx[m] < NT) ? aw_idx[m] : 0;
            m_awvalid[m] = awv[m];
            m_awid[m*ID_W +: ID_W] = ID_W'(ai);
            m_awaddr[m*32 +: 32] = t_addr[m][ai];
            m_awlen[m*8 +: 8] = 8'(t_len[m][ai]);
            if (!wv[m] && w_idx[m] < w_lim[m] && roll(pr_wv)) wv[m] = 1;
            wi = (w_idx[m] < NT) ? w_idx[m] : 0;
            m_wvalid[m] = wv[m];
            m_wdata[m*32 +: 32] = exp_data(m, wi, w_beat[m]);
            m_wstrb[m*4 +: 4] = 4'hF;
            m_wlast[m] = (w_beat[m] == t_len[m][wi]);
            m_bready[m] = roll(pr_br);
        end
        for (int s = 0; s < 2; s++) begin
            int bm, bk;
            s_awready[s] = roll(pr_ar);
            s_wready[s] = roll(pr_wr);
            if (!bv[s] && bq_rd[s] != bq_wr[s] && roll(pr_bv)) bv[s] = 1;
            bm = bq_m[s][bq_rd[s] % QS];
            bk = bq_k[s][bq_rd[s] % QS];
            s_bvalid[s] = bv[s];
            s_bid[s*XID_W +: XID_W] = {1'(bm), ID_W'(bk)};
            s_bresp[s*2 +: 2] = exp_resp(bm, bk);
        end
    endtask

    task automatic sample();
        // R9: stalled AW toward a slave and stalled B toward a master hold steady
        for (int s = 0; s < 2; s++)
            if (st_aw[s])
                chk(s_awvalid[s] && s_awid[s*XID_W +: XID_W] == st_awid[s]
                    && s_awaddr[s*32 +: 32] == st_addr[s], "R9", "aw held",
                    s_awaddr[s*32 +: 32], st_addr[s]);
        for (int m = 0; m < 2; m++)
            if (st_b[m])
                chk(m_bvalid[m] && m_bid[m*ID_W +: ID_W] == st_bid[m], "R9", "b held",
                    m_bid[m*ID_W +: ID_W], st_bid[m]);
        if (phase == 2 && m_wready[1]) m1_wready_cnt++;
        // master W handshakes
        for (int m = 0; m < 2; m++)
            if (wv[m] && m_wready[m]) begin
                chk(w_idx[m] < aw_idx[m], "R4", "w before its aw", w_idx[m], aw_idx[m]);
                wv[m] = 0;
                if (w_beat[m] == t_len[m][w_idx[m]]) begin
                    w_idx[m]++;
                    w_beat[m] = 0;
                end else w_beat[m]++;
            end
        // slave AW handshakes
        for (int s = 0; s < 2; s++)
            if (s_awvalid[s] && s_awready[s]) begin
                int mm, k;
                mm = int'(s_awid[s*XID_W + ID_W]);
                k = aw_idx[mm];
                slv_aw_total++;
                chk(awv[mm] && m_awready[mm], "R2", "prefix names presenting master", mm, mm);
                chk(s_awid[s*XID_W +: XID_W] == {1'(mm), ID_W'(k)}, "R2", "widened id",
                    s_awid[s*XID_W +: XID_W], {1'(mm), ID_W'(k)});
                chk(s_awaddr[s*32 +: 32] == t_addr[mm][k] && t_tgt[mm][k] == s
                    && s_awlen[s*8 +: 8] == 8'(t_len[mm][k]), "R1", "decode/addr",
                    s_awaddr[s*32 +: 32], t_addr[mm][k]);
                so_m[s][so_wr[s] % QS] = mm;
                so_k[s][so_wr[s] % QS] = k;
                so_wr[s]++;
                if (s == 0 && phase == 1 && g0_n < 16) begin
                    g0_log[g0_n] = mm;
                    g0_n++;
                end
            end
        for (int m = 0; m < 2; m++)
            if (awv[m] && m_awready[m]) begin
                aw_idx[m]++;
                awv[m] = 0;
            end
        // slave W handshakes
        for (int s = 0; s < 2; s++)
            if (s_wvalid[s] && s_wready[s]) begin
                int mm, k;
                if (so_rd[s] == so_wr[s]) begin
                    chk(0, "R6", "w beat with no accepted aw", so_rd[s], so_wr[s]);
                end else begin
                    mm = so_m[s][so_rd[s] % QS];
                    k = so_k[s][so_rd[s] % QS];
                    chk(s_wdata[s*32 +: 32] == exp_data(mm, k, sb_beat[s]), "R6", "w data order",
                        s_wdata[s*32 +: 32], exp_data(mm, k, sb_beat[s]));
                    chk(s_wlast[s] == (sb_beat[s] == t_len[mm][k]), "R5", "w last",
                        s_wlast[s], sb_beat[s] == t_len[mm][k]);
                    if (sb_beat[s] == t_len[mm][k]) begin
                        so_rd[s]++;
                        sb_beat[s] = 0;
                        bq_m[s][bq_wr[s] % QS] = mm;
                        bq_k[s][bq_wr[s] % QS] = k;
                        bq_wr[s]++;
                    end else sb_beat[s]++;
                end
            end
        for (int s = 0; s < 2; s++)
            if (bv[s] && s_bready[s]) begin
                bq_rd[s]++;
                bv[s] = 0;
            end
        // master B handshakes
        for (int m = 0; m < 2; m++)
            if (m_bvalid[m] && m_bready[m]) begin
                int hitk;
                hitk = -1;
                for (int k = 0; k < w_idx[m]; k++)
                    if (!b_got[m][k] && ID_W'(k) == m_bid[m*ID_W +: ID_W]) hitk = k;
                chk(hitk >= 0, "R7", "b id matches pending write", m_bid[m*ID_W +: ID_W], 0);
                if (hitk >= 0) begin
                    chk(m_bresp[m*2 +: 2] == exp_resp(m, hitk), "R7", "b resp",
                        m_bresp[m*2 +: 2], exp_resp(m, hitk));
                    b_got[m][hitk] = 1;
                end
                b_cnt[m]++;
            end
        for (int s = 0; s < 2; s++) begin
            st_aw[s] = s_awvalid[s] && !s_awready[s];
            st_awid[s] = s_awid[s*XID_W +: XID_W];
            st_addr[s] = s_awaddr[s*32 +: 32];
        end
        for (int m = 0; m < 2; m++) begin
            st_b[m] = m_bvalid[m] && !m_bready[m];
            st_bid[m] = m_bid[m*ID_W +: ID_W];
        end
    endtask

    task automatic tick();
        drive();
        #2;
        sample();
        @(posedge clk);
        #1;
        cycles++;
        if (cycles > WDOG && !timed_out) begin
            timed_out = 1;
            chk(0, "R5", "watchdog expired", cycles, WDOG);
        end
    endtask

    function automatic bit all_done(int n);
        return b_cnt[0] == n && b_cnt[1] == n;
    endfunction

    initial begin
        void'($urandom(32'd20250401));
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < NT; k++) begin
                t_tgt[m][k] = $urandom_range(1);
                t_len[m][k] = (k % 13 == 5) ? 15 : $urandom_range(7);
            end
        for (int k = 0; k < 6; k++) begin
            t_tgt[0][k] = 0;
            t_tgt[1][k] = 0;
        end
        for (int k = 6; k < 11; k++) t_tgt[0][k] = 1;
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < NT; k++)
                t_addr[m][k] = ($urandom & ~32'h0001_0000) | (32'(t_tgt[m][k]) << SEL_BIT);
        for (int i = 0; i < 2; i++) begin
            aw_idx[i] = 0; w_idx[i] = 0; w_beat[i] = 0; b_cnt[i] = 0;
            awv[i] = 0; wv[i] = 0; bv[i] = 0; so_wr[i] = 0; so_rd[i] = 0;
            sb_beat[i] = 0; bq_wr[i] = 0; bq_rd[i] = 0; st_aw[i] = 0; st_b[i] = 0;
            aw_lim[i] = 0; w_lim[i] = 0;
            for (int k = 0; k < NT; k++) b_got[i][k] = 0;
        end
        m_awvalid = '0; m_awid = '0; m_awaddr = '0; m_awlen = '0; m_wdata = '0;
        m_wstrb = '0; m_wlast = '0; m_wvalid = '0; m_bready = '0;
        s_awready = '0; s_wready = '0; s_bid = '0; s_bresp = '0; s_bvalid = '0;

        rst_n = 1'b0;
        m_awvalid = 2'b11;
        m_wvalid = 2'b11;
        s_awready = 2'b11;
        repeat (3) @(posedge clk);
        #3;
        chk(s_awvalid == 2'b00 && s_wvalid == 2'b00, "R10", "slave valids in reset",
            {s_awvalid, s_wvalid}, 0);
        chk(m_bvalid == 2'b00 && m_awready == 2'b00, "R10", "master outputs in reset",
            {m_bvalid, m_awready}, 0);
        m_awvalid = '0; m_wvalid = '0; s_awready = '0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // phase 1: both masters contend for slave 0 (R3)
        phase = 1;
        pr_av = 100; pr_wv = 100; pr_ar = 100; pr_wr = 100; pr_bv = 100; pr_br = 100;
        aw_lim[0] = 6; aw_lim[1] = 6; w_lim[0] = 6; w_lim[1] = 6;
        while (!all_done(6) && !timed_out) tick();
        for (int i = 0; i < 6; i++)
            chk(g0_n >= 6 && g0_log[i] == (i % 2), "R3", "round-robin grant order",
                g0_log[i], i % 2);

        // phase 2: master 0 fills its route queue, master 1 sends W without AW (R8, R4)
        phase = 2;
        aw_lim[0] = 11; w_lim[0] = 6; aw_lim[1] = 6; w_lim[1] = 7;
        repeat (40) if (!timed_out) tick();
        chk(aw_idx[0] == 6 + DEPTH, "R8", "accepted before queue full", aw_idx[0], 6 + DEPTH);
        chk(awv[0] && m_awready[0] == 1'b0, "R8", "awready low with full queue", m_awready[0], 0);
        chk(aw_idx[0] - w_idx[0] == DEPTH, "R5", "several writes outstanding",
            aw_idx[0] - w_idx[0], DEPTH);
        chk(m1_wready_cnt == 0 && w_idx[1] == 6, "R4", "w ready held low without aw",
            m1_wready_cnt, 0);

        // phase 3: random traffic with back-pressure everywhere
        phase = 3;
        pr_av = 70; pr_wv = 65; pr_ar = 55; pr_wr = 60; pr_bv = 60; pr_br = 50;
        aw_lim[0] = NT; aw_lim[1] = NT; w_lim[0] = NT; w_lim[1] = NT;
        while (!all_done(NT) && !timed_out) tick();
        chk(slv_aw_total == 2 * NT, "R1", "every aw reached a slave", slv_aw_total, 2 * NT);
        chk(so_rd[0] == so_wr[0] && so_rd[1] == so_wr[1], "R6", "all bursts drained in order",
            so_rd[0] + so_rd[1], so_wr[0] + so_wr[1]);
        chk(b_cnt[0] == NT && b_cnt[1] == NT, "R7", "all responses returned",
            b_cnt[0] + b_cnt[1], 2 * NT);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule